// File: doc/BRIEF.md
# Serial DAC Control Register Receiver

This block is the digital front end of an 8-bit voltage-output converter. A host writes to it over a write-only three-wire serial link: an active-low frame-select line, a serial clock and a data line. The block samples all three lines with its own faster system clock. It assembles a 16-bit frame, most significant bit first, and on the sixteenth falling serial-clock edge commits the frame's two-bit power-down mode and its 8-bit code together.

A frame whose select line rises before the sixteenth falling edge is abandoned. Nothing it carried reaches the held registers. The held code is never cleared by entering a power-down mode. A one-hot termination select and an "effective level" code go to the analog section. The effective level is the held code in normal mode and zero in any power-down mode. A one-cycle strobe marks each commit.

Top module: `serdac_rx`

## Requirements
- R1: After reset the held code is 0, the mode is normal (00), the termination select is 4'b0001, the effective level is 0 and the update strobe is low.
- R2: A frame starts on a falling edge of the active-low frame-select line. While that line stays low, each falling serial-clock edge shifts in one data bit, the most significant frame bit first.
- R3: On the sixteenth falling edge, the held mode takes frame bits 13:12 and the held code takes frame bits 11:4. Frame bits 15:14 and 3:0 have no effect.
- R4: Mode encodings are 00 normal drive, 01 pulldown of 1 kOhm, 10 pulldown of 100 kOhm and 11 high impedance. The termination select sets exactly one bit: bit 0 for 00, bit 1 for 01, bit 2 for 10 and bit 3 for 11.
- R5: If frame-select rises after fewer than sixteen falling edges, the partial frame is discarded. No update strobe is produced, and the held code and mode keep their values.
- R6: The effective level equals the held code when the mode is 00 and is 0 in any other mode. A power-down mode does not clear the held code, so a later normal frame restores a nonzero level.
- R7: Falling serial-clock edges after the sixteenth, while frame-select stays low, are ignored until frame-select goes high.
- R8: The update strobe is high for exactly one system-clock cycle per complete frame and never otherwise.
- R9: A new frame requires frame-select to go high and fall again. A frame that follows an aborted one decodes correctly, with no bits left over from the aborted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| fsel_n_i | input | 1 | Active-low frame select, asynchronous |
| sdin_i | input | 1 | Serial data, asynchronous |
| dac_code_o | output | 8 | Held 8-bit code |
| pd_mode_o | output | 2 | Held power-down mode |
| term_sel_o | output | 4 | One-hot output termination select |
| level_code_o | output | 8 | Effective level code (0 while powered down) |
| update_o | output | 1 | One-cycle strobe on each commit |

## Verification
Complete frames are sent with each of the four mode values. Some carry ones in the don't-care bits, so a wrong field slice shows up as a wrong code or mode. Codes at both ends of the range and asymmetric patterns such as A5 and 81 separate MSB-first from LSB-first shifting. Frames aborted after 8 and after 15 edges, the latter one edge short of a commit, show whether an early select rise leaks into the held state, and the full frame that follows shows whether leftover bits corrupt it. A frame padded with extra clock edges shows whether the receiver keeps shifting past the sixteenth edge. Power-down frames followed by a normal frame separate "level forced to zero" from "code cleared".

// File: rtl/serdac_pkg.sv
// Shared types and constants for the serial DAC control receiver.
// Assumes a 16-bit frame with the field positions fixed by the frame format.
package serdac_pkg;
    localparam int MODE_W = 2;
    localparam int TERM_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_DRIVE   = 2'b00,
        MODE_PD_1K   = 2'b01,
        MODE_PD_100K = 2'b10,
        MODE_PD_HIZ  = 2'b11
    } pd_mode_e;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'b00,
        FR_SHIFT = 2'b01,
        FR_DONE  = 2'b10
    } frame_st_e;

    localparam int TERM_DRIVE = 0;
    localparam int TERM_1K    = 1;
    localparam int TERM_100K  = 2;
    localparam int TERM_HIZ   = 3;
endpackage

// File: rtl/serdac_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes each line is a level that stays stable for several clk cycles.
module serdac_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: captures the raw asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later flops: let metastability resolve.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/serdac_edge.sv
// Edge detector for synchronized lines in the system clock domain.
// Assumes inputs come from serdac_sync; outputs are single-cycle pulses.
module serdac_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's level to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;
    assign rise_o = ~prev_q & level_i;
endmodule

// File: rtl/serdac_framer.sv
// Frame assembler: starts on a select fall and shifts one bit per serial-clock
// fall, MSB first. On the last edge it emits the mode and code fields with a
// one-cycle commit pulse. An early select rise discards the partial frame.
// Edges after the last one are ignored until select goes high.
// Assumes the inputs are already synchronized edge/level indications.
module serdac_framer
    import serdac_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int DATA_W   = 8,
    parameter int DATA_LSB = 4,
    parameter int MODE_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall_i,
    input  logic              fsel_fall_i,
    input  logic              fsel_low_i,
    input  logic              sd_bit_i,
    output logic              commit_o,
    output pd_mode_e          mode_o,
    output logic [DATA_W-1:0] code_o
);
    // Only frame bits up to the top of the mode field need storing; the
    // just-arrived bit is frame bit 0, so stored bit k is frame bit k+1.
    localparam int SR_W  = MODE_LSB + MODE_W - 1;
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_W - 1);

    frame_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SR_W-1:0]  sr_q;

    // Frame state machine, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FR_IDLE;
            cnt_q    <= '0;
            sr_q     <= '0;
            commit_o <= 1'b0;
            mode_o   <= MODE_DRIVE;
            code_o   <= '0;
        end else begin
            commit_o <= 1'b0;
            case (st_q)
                FR_IDLE: begin
                    if (fsel_fall_i) begin
                        st_q  <= FR_SHIFT;
                        cnt_q <= '0;
                        sr_q  <= '0;
                    end
                end
                FR_SHIFT: begin
                    if (!fsel_low_i) begin
                        st_q  <= FR_IDLE;
                        cnt_q <= '0;
                        sr_q  <= '0;
                    end else if (sclk_fall_i) begin
                        sr_q <= {sr_q[SR_W-2:0], sd_bit_i};
                        if (cnt_q == LAST_EDGE) begin
                            commit_o <= 1'b1;
                            mode_o   <= pd_mode_e'(sr_q[MODE_LSB-1 +: MODE_W]);
                            code_o   <= sr_q[DATA_LSB-1 +: DATA_W];
                            st_q     <= FR_DONE;
                            cnt_q    <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                FR_DONE: begin
                    if (!fsel_low_i) st_q <= FR_IDLE;
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end

    // R5: a select rise during shifting never yields a commit.
    p_abort_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_SHIFT && !fsel_low_i) |=> !commit_o);

    // R8: the commit pulse lasts a single cycle.
    p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R7: a commit always leaves the framer waiting for select to rise.
    p_commit_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> st_q == FR_DONE);

    // R7: while done and select low, no further commit and no restart.
    p_done_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_DONE && fsel_low_i) |=> (st_q == FR_DONE && !commit_o));
endmodule

// File: rtl/serdac_hold.sv
// Held DAC code and mode registers plus termination and level decode.
// Registers load only on a commit; power-down never clears the code.
// Assumes commit_i is a single-cycle pulse with stable fields.
module serdac_hold
    import serdac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  pd_mode_e          mode_i,
    input  logic [DATA_W-1:0] code_i,
    output logic [DATA_W-1:0] code_o,
    output pd_mode_e          mode_o,
    output logic [TERM_W-1:0] term_o,
    output logic [DATA_W-1:0] level_o,
    output logic              update_o
);
    logic [DATA_W-1:0] code_q;
    pd_mode_e          mode_q;
    logic              upd_q;

    // Load code and mode together on a commit; pulse the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mode_q <= MODE_DRIVE;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= commit_i;
            if (commit_i) begin
                code_q <= code_i;
                mode_q <= mode_i;
            end
        end
    end

    // Decode the mode into a one-hot termination select.
    always_comb begin
        term_o = '0;
        case (mode_q)
            MODE_DRIVE:   term_o[TERM_DRIVE] = 1'b1;
            MODE_PD_1K:   term_o[TERM_1K]    = 1'b1;
            MODE_PD_100K: term_o[TERM_100K]  = 1'b1;
            default:      term_o[TERM_HIZ]   = 1'b1;
        endcase
    end

    // Effective level: the held code in normal drive, zero when powered down.
    always_comb begin
        level_o = (mode_q == MODE_DRIVE) ? code_q : '0;
    end

    assign code_o   = code_q;
    assign mode_o   = mode_q;
    assign update_o = upd_q;

    // R5: without a commit the held code does not move.
    p_code_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(code_q));

    // R5: without a commit the held mode does not move.
    p_mode_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mode_q));
endmodule

// File: rtl/serdac_rx.sv
// Top of the serial DAC control receiver: synchronizes the three serial lines,
// detects their edges, assembles frames and holds the committed mode and code.
// Assumes the serial clock half period spans several system clock cycles.
module serdac_rx
    import serdac_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int DATA_W      = 8,
    parameter int DATA_LSB    = 4,
    parameter int MODE_LSB    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fsel_n_i,
    input  logic              sdin_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic [1:0]        pd_mode_o,
    output logic [3:0]        term_sel_o,
    output logic [DATA_W-1:0] level_code_o,
    output logic              update_o
);
    // Line order inside the synchronized bundle.
    localparam int LN_SD   = 0;
    localparam int LN_SCLK = 1;
    localparam int LN_FSEL = 2;
    localparam int LINES   = 3;
    localparam logic [LINES-1:0] LINE_RST = 3'b110;

    logic [LINES-1:0]  lines_s;
    logic [1:0]        fall_w;
    logic [1:0]        rise_w;
    logic              commit_w;
    pd_mode_e          fr_mode_w;
    logic [DATA_W-1:0] fr_code_w;
    pd_mode_e          hold_mode_w;
    logic [TERM_W-1:0] term_w;

    serdac_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fsel_n_i, sclk_i, sdin_i}),
        .sync_o  (lines_s)
    );

    serdac_edge #(.WIDTH(2), .RST_VAL(2'b11)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({lines_s[LN_FSEL], lines_s[LN_SCLK]}),
        .fall_o  (fall_w),
        .rise_o  (rise_w)
    );

    serdac_framer #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W),
        .DATA_LSB(DATA_LSB),
        .MODE_LSB(MODE_LSB)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall_i(fall_w[0]),
        .fsel_fall_i(fall_w[1]),
        .fsel_low_i (!lines_s[LN_FSEL]),
        .sd_bit_i   (lines_s[LN_SD]),
        .commit_o   (commit_w),
        .mode_o     (fr_mode_w),
        .code_o     (fr_code_w)
    );

    serdac_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit_w),
        .mode_i  (fr_mode_w),
        .code_i  (fr_code_w),
        .code_o  (dac_code_o),
        .mode_o  (hold_mode_w),
        .term_o  (term_w),
        .level_o (level_code_o),
        .update_o(update_o)
    );

    assign pd_mode_o  = hold_mode_w;
    assign term_sel_o = term_w;

    // R9: a frame can begin only from a select fall, never on a select rise.
    p_rise_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w[1] |=> !commit_w);

    // Edge pulses on the select line are mutually exclusive.
    p_sel_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_w[1] && rise_w[1]));
endmodule

// File: tb/serdac_rx_test.sv
// Scoreboard bench: the driver queues the expected result of each complete
// frame, the monitor pops and compares it when the update strobe fires.
module serdac_rx_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] code;
        logic [1:0] mode;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       fsel_n = 1'b1;
    logic       sdin = 1'b0;
    logic [7:0] dac_code;
    logic [1:0] pd_mode;
    logic [3:0] term_sel;
    logic [7:0] level_code;
    logic       update;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   mon_checks = 0;
    int   mon_errors = 0;
    int   mon_updates = 0;
    logic [7:0] last_code = 8'h00;
    logic [1:0] last_mode = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    serdac_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .fsel_n_i    (fsel_n),
        .sdin_i      (sdin),
        .dac_code_o  (dac_code),
        .pd_mode_o   (pd_mode),
        .term_sel_o  (term_sel),
        .level_code_o(level_code),
        .update_o    (update)
    );

    // Frame word: junk in 15:14 and 3:0, mode in 13:12, code in 11:4.
    function automatic logic [15:0] mk(input logic [1:0] m, input logic [7:0] c,
                                       input logic [5:0] junk);
        return {junk[5:4], m, c, junk[3:0]};
    endfunction

    function automatic logic [3:0] term_of(input logic [1:0] m);
        return 4'b0001 << m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial clock falling edge carrying bit b.
    task automatic clock_bit(input logic b);
        sdin = b;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Send nfall bits of w MSB first, then extra edges, then raise select.
    task automatic send_frame(input logic [15:0] w, input int nfall, input int extra);
        exp_t e;
        if (nfall >= 16) begin
            e.code = w[11:4];
            e.mode = w[13:12];
            exp_q.push_back(e);
            last_code = w[11:4];
            last_mode = w[13:12];
        end
        @(negedge clk);
        fsel_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nfall; i++) clock_bit(w[15-i]);
        for (int i = 0; i < extra; i++) clock_bit(i[0]);
        fsel_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Monitor: on each update strobe compare held outputs with the queue head.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && update) begin
                mon_updates++;
                if (exp_q.size() == 0) begin
                    mon_checks++;
                    mon_errors++;
                    $display("FAIL R8 actual=unexpected update expected=none");
                end else begin
                    e = exp_q.pop_front();
                    mon_checks += 4;
                    if (dac_code !== e.code) begin
                        mon_errors++;
                        $display("FAIL R3 code actual=%0h expected=%0h", dac_code, e.code);
                    end
                    if (pd_mode !== e.mode) begin
                        mon_errors++;
                        $display("FAIL R3 mode actual=%0h expected=%0h", pd_mode, e.mode);
                    end
                    if (term_sel !== term_of(e.mode)) begin
                        mon_errors++;
                        $display("FAIL R4 term actual=%0h expected=%0h", term_sel, term_of(e.mode));
                    end
                    if (level_code !== ((e.mode == 2'b00) ? e.code : 8'h00)) begin
                        mon_errors++;
                        $display("FAIL R6 level actual=%0h expected=%0h", level_code,
                                 (e.mode == 2'b00) ? e.code : 8'h00);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

    task automatic check_held(input string req);
        check(req, {24'h0, dac_code}, {24'h0, last_code});
        check(req, {30'h0, pd_mode}, {30'h0, last_mode});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state.
        check("R1 code", {24'h0, dac_code}, 32'h0);
        check("R1 mode", {30'h0, pd_mode}, 32'h0);
        check("R1 term", {28'h0, term_sel}, 32'h1);
        check("R1 level", {24'h0, level_code}, 32'h0);
        check("R1 update", {31'h0, update}, 32'h0);

        // R2/R3: normal frame, don't-care bits set, asymmetric code.
        send_frame(mk(2'b00, 8'hA5, 6'h3F), 16, 0);
        check("R2 msb-first code", {24'h0, dac_code}, 32'hA5);
        // R4/R6: each power-down mode with the same code field.
        send_frame(mk(2'b01, 8'h5A, 6'h00), 16, 0);
        check("R6 level zero in pd", {24'h0, level_code}, 32'h0);
        check("R6 code kept in pd", {24'h0, dac_code}, 32'h5A);
        send_frame(mk(2'b10, 8'h5A, 6'h15), 16, 0);
        check("R4 term 100k", {28'h0, term_sel}, 32'h4);
        send_frame(mk(2'b11, 8'h5A, 6'h2A), 16, 0);
        check("R4 term hiz", {28'h0, term_sel}, 32'h8);
        send_frame(mk(2'b00, 8'h5A, 6'h00), 16, 0);
        check("R6 level restored", {24'h0, level_code}, 32'h5A);

        // R5: aborted frames, one well short and one a single edge short.
        send_frame(mk(2'b11, 8'hFF, 6'h3F), 8, 0);
        check_held("R5 abort after 8");
        send_frame(mk(2'b11, 8'hFF, 6'h3F), 15, 0);
        check_held("R5 abort after 15");
        check("R5 level unchanged", {24'h0, level_code}, 32'h5A);

        // R9: a full frame straight after an abort decodes cleanly.
        // R7: extra clock edges after the 16th are ignored.
        send_frame(mk(2'b00, 8'h81, 6'h2A), 16, 5);
        check_held("R9 frame after abort / R7 extra edges");

        // Code range ends.
        send_frame(mk(2'b00, 8'hFF, 6'h00), 16, 0);
        check("R3 full scale", {24'h0, level_code}, 32'hFF);
        send_frame(mk(2'b00, 8'h00, 6'h3F), 16, 0);
        check("R3 zero code", {24'h0, dac_code}, 32'h00);

        // R8: one strobe per complete frame, none left pending.
        repeat (10) @(negedge clk);
        check("R8 update count", mon_updates, 32'd8);
        check("R8 queue empty", exp_q.size(), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks, errors + mon_errors);
        $finish;
    end
endmodule